// File: doc/BRIEF.md
# Discrete-Input Serial Port

This block is the serial front door of an eight-channel discrete-input sensor. A host talks to it over a four-wire SPI-style link plus a register-select pin. In a read cycle the block freezes the present levels of all channel inputs when chip select drops, then streams them out one bit per serial clock, highest channel first. In a write cycle the host streams a byte in, and the block moves it into a per-channel mode register when chip select returns high. That register drives a parallel mode bus into the analog front end.

The shift path is a single eight-bit register. Bits arriving on serial data in fall through it and reappear on serial data out eight clocks later. Two or more devices can therefore be chained on one select line and clocked through 16-bit (or longer) cycles. All serial pins are oversampled by the block's own system clock. Serial data in is taken on the rising serial-clock edge and serial data out advances on the falling edge. The first status bit is on the pin shortly after chip select falls.

Top module: `din_serial_port`

## Requirements
- R1: `sdoEn` is 0 out of reset and while chip select is high, and 1 for the whole of a cycle from shortly after chip select falls until shortly after it rises.
- R2: When chip select falls, `chanIn` is captured in parallel. Changes on `chanIn` later in the cycle do not alter the bits shifted out.
- R3: The captured status leaves `sdo` as `chanIn[7]` first, down to `chanIn[0]` as the eighth bit. Each following bit appears after a falling serial-clock edge.
- R4: In a cycle longer than eight clocks, the bit sampled from `sdi` on rising edge k appears on `sdo` as output bit k+8, so the block acts as an eight-bit delay.
- R5: In a write cycle (`regSel` high when chip select falls) of eight or more clocks, the last eight bits taken from `sdi` are loaded into `chanMode` when chip select rises. The first of those eight bits goes to `chanMode[7]`. `chanMode` changes at no other time except reset.
- R6: A write cycle that ends after fewer than eight rising serial-clock edges leaves `chanMode` unchanged.
- R7: `regSel` is sampled only when chip select falls. A read cycle (`regSel` low then) leaves `chanMode` unchanged even if `regSel` goes high later in the cycle.
- R8: While `rstN` is low, `chanMode` is all zeros, which selects the default open/pull-down mode on every channel. This holds even when reset strikes after a write.
- R9: The write result is the same whether chip select rises after the final falling serial-clock edge or while the serial clock is still high after the eighth rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| regSel | input | 1 | Cycle type: 0 read status, 1 write mode register |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdoEn | output | 1 | Output enable for `sdo` (tri-state control) |
| chanIn | input | NCH | Discrete input levels, one per channel |
| chanMode | output | NCH | Per-channel mode bits to the front end |

## Verification
The hardest case to reach from the pins is a write that ends while the last sampled bit is still waiting in the input hold stage. In that case chip select rises with the serial clock high, before the eighth falling edge has moved the bit into the shift register. The vector table has a per-entry flag that either issues or withholds the trailing falling edge, and it uses this flag on both 8- and 16-clock writes. Every cycle also flips `chanIn` and `regSel` right after the first rising edge. This shows in all runs that only values taken at chip-select fall count.

// File: rtl/din_spi_pkg.sv
package din_spi_pkg;

  // Strobes from the control to the datapath, one system clock wide except active
  typedef struct packed {
    logic load;    // capture inputs into the shift register
    logic sample;  // take a bit from serial data in
    logic shift;   // advance the shift register
    logic commit;  // move shift contents to the mode register
    logic active;  // a cycle is in progress
  } strb_t;

endpackage

// File: rtl/din_spi_ctrl.sv
module din_spi_ctrl
  import din_spi_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  csN,
  input  logic  regSel,
  input  logic  sclk,
  input  logic  sdi,
  output logic  sdiSync,
  output strb_t strobes
);

  localparam int CNT_W   = $clog2(NCH + 1);
  localparam int N_PINS  = 3;
  localparam logic [N_PINS-1:0] PIN_IDLE = 3'b100; // {csN, sclk, sdi}

  logic [N_PINS-1:0] pinRaw;
  logic [N_PINS-1:0] syncStage [SYNC_STAGES];
  logic [N_PINS-1:0] pinSync;

  assign pinRaw = {csN, sclk, sdi};

  // Synchronizer chain, one register per stage
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncStage[s] <= PIN_IDLE;
      end else if (s == 0) begin
        syncStage[s] <= pinRaw;
      end else begin
        syncStage[s] <= syncStage[(s > 0) ? s - 1 : 0];
      end
    end
  end

  assign pinSync = syncStage[SYNC_STAGES-1];
  assign sdiSync = pinSync[0];

  logic csNowN, sclkNow, csPrevN, sclkPrev;
  assign csNowN  = pinSync[2];
  assign sclkNow = pinSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrevN  <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrevN  <= csNowN;
      sclkPrev <= sclkNow;
    end
  end

  logic csFall, csRise, sclkRise, sclkFall;
  assign csFall   = csPrevN & ~csNowN;
  assign csRise   = ~csPrevN & csNowN;
  assign sclkRise = ~sclkPrev & sclkNow;
  assign sclkFall = sclkPrev & ~sclkNow;

  logic             inCycle;
  logic             writeCycle;
  logic [CNT_W-1:0] riseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inCycle    <= 1'b0;
      writeCycle <= 1'b0;
      riseCnt    <= '0;
    end else if (csFall) begin
      inCycle    <= 1'b1;
      writeCycle <= regSel;
      riseCnt    <= '0;
    end else if (csRise) begin
      inCycle    <= 1'b0;
    end else if (inCycle && sclkRise && riseCnt != CNT_W'(NCH)) begin
      riseCnt    <= riseCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.load   = csFall;
    strobes.sample = inCycle & ~csRise & sclkRise;
    strobes.shift  = inCycle & ~csRise & sclkFall;
    strobes.commit = inCycle & csRise & writeCycle & (riseCnt == CNT_W'(NCH));
    strobes.active = inCycle;
  end

endmodule

// File: rtl/din_spi_datapath.sv
module din_spi_datapath
  import din_spi_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  strb_t          strobes,
  input  logic           sdiSync,
  input  logic [NCH-1:0] chanIn,
  output logic           sdo,
  output logic           sdoEn,
  output logic [NCH-1:0] chanMode
);

  logic [NCH-1:0] shiftReg;
  logic           sdiHold;
  logic           holdPending;
  logic [NCH-1:0] shiftNext;

  // Contents the register would hold once the pending bit is shifted in
  assign shiftNext = {shiftReg[NCH-2:0], sdiHold};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      sdiHold     <= 1'b0;
      holdPending <= 1'b0;
    end else if (strobes.load) begin
      shiftReg    <= chanIn;
      holdPending <= 1'b0;
    end else if (strobes.sample) begin
      sdiHold     <= sdiSync;
      holdPending <= 1'b1;
    end else if (strobes.shift && holdPending) begin
      shiftReg    <= shiftNext;
      holdPending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanMode <= '0;
    end else if (strobes.commit) begin
      chanMode <= holdPending ? shiftNext : shiftReg;
    end
  end

  assign sdo   = shiftReg[NCH-1];
  assign sdoEn = strobes.active;

endmodule

// File: rtl/din_serial_port.sv
module din_serial_port
  import din_spi_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           csN,
  input  logic           regSel,
  input  logic           sclk,
  input  logic           sdi,
  output logic           sdo,
  output logic           sdoEn,
  input  logic [NCH-1:0] chanIn,
  output logic [NCH-1:0] chanMode
);

  strb_t strobes;
  logic  sdiSync;

  din_spi_ctrl #(.NCH(NCH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .regSel(regSel),
    .sclk(sclk), .sdi(sdi), .sdiSync(sdiSync), .strobes(strobes)
  );

  din_spi_datapath #(.NCH(NCH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sdiSync(sdiSync),
    .chanIn(chanIn), .sdo(sdo), .sdoEn(sdoEn), .chanMode(chanMode)
  );

endmodule

// File: rtl/din_serial_port_chk.sv
module din_serial_port_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic [NCH-1:0] chanIn,
  input logic [NCH-1:0] chanMode,
  input logic           sdo,
  input logic           sdoEn,
  input logic           loadStb,
  input logic           sampleStb,
  input logic           commitStb
);

  localparam int CW = $clog2(NCH + 1);
  logic [CW-1:0] seenRises;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenRises <= '0;
    else if (loadStb) seenRises <= '0;
    else if (sampleStb && seenRises != CW'(NCH)) seenRises <= seenRises + 1'b1;
  end

  // R8: mode register is zero under reset
  always_ff @(posedge clk) begin
    if (!rstN) a_r8_reset_default: assert (chanMode == '0);
  end

  // R1: output enabled once a cycle is entered
  a_r1_enable_on_load: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> sdoEn);

  // R2 / R3: highest channel is on sdo right after capture
  a_r3_first_bit_msb: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> (sdo == $past(chanIn[NCH-1])));

  // R5: mode register only moves on a commit
  a_r5_mode_only_on_commit: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(chanMode) |-> $past(commitStb));

  // R6: no commit before a full byte of rising edges
  a_r6_full_byte_needed: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> (seenRises == CW'(NCH)));

endmodule

bind din_serial_port din_serial_port_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rstN(rstN), .chanIn(chanIn), .chanMode(chanMode),
  .sdo(sdo), .sdoEn(sdoEn), .loadStb(strobes.load),
  .sampleStb(strobes.sample), .commitStb(strobes.commit)
);

// File: tb/din_serial_port_bench.sv
module din_serial_port_bench;

  localparam int HALF = 6;  // system clocks per serial half period

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, regSel = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdoEn;
  logic [7:0] chanIn = 8'h00;
  logic [7:0] chanMode;

  int checks = 0;
  int errors = 0;
  logic [7:0] expMode = 8'h00;

  always #4 clk = ~clk;  // 125 MHz

  din_serial_port u_din_serial_port (
    .clk(clk), .rstN(rstN), .csN(csN), .regSel(regSel), .sclk(sclk),
    .sdi(sdi), .sdo(sdo), .sdoEn(sdoEn), .chanIn(chanIn), .chanMode(chanMode)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One serial cycle; rx holds bits seen before each rising edge, first bit in MSB position
  task automatic serialCycle(input logic sel, input logic trail, input int nbits,
                             input logic [7:0] chan, input logic [15:0] tx,
                             output logic [15:0] rx);
    rx = '0;
    chanIn = chan;
    regSel = sel;
    waitClk(HALF);
    csN = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      sdi = tx[nbits-1-i];
      waitClk(HALF);
      if (i == 0) check("R1 enable in cycle", {15'd0, sdoEn}, 16'd1);
      rx = {rx[14:0], sdo};
      sclk = 1'b1;
      if (i == 0) begin
        chanIn = ~chan;   // R2: late input change
        regSel = ~sel;    // R7: late select change
      end
      waitClk(HALF);
      if (i < nbits - 1 || trail) sclk = 1'b0;
    end
    waitClk(HALF);
    csN = 1'b1;
    waitClk(HALF);
    sclk = 1'b0;
    waitClk(HALF);
    check("R1 disable after cycle", {15'd0, sdoEn}, 16'd0);
  endtask

  function automatic logic [15:0] expRx(input int nbits, input logic [7:0] chan,
                                        input logic [15:0] tx);
    logic [15:0] r = '0;
    for (int i = 0; i < nbits; i++)
      r = {r[14:0], (i < 8) ? chan[7-i] : tx[nbits-1-(i-8)]};
    return r;
  endfunction

  // {sel, trail, nbits[4:0], chan[7:0], tx[15:0]}
  localparam logic [30:0] VEC [8] = '{
    {1'b0, 1'b1, 5'd8,  8'hA5, 16'h0000},  // R3 plain read
    {1'b0, 1'b1, 5'd16, 8'h3C, 16'hC96B},  // R4 chained read
    {1'b1, 1'b1, 5'd8,  8'h0F, 16'h0096},  // R5 write with trailing edge
    {1'b1, 1'b0, 5'd8,  8'hF0, 16'h005A},  // R9 write without trailing edge
    {1'b1, 1'b0, 5'd16, 8'h81, 16'h7E33},  // R9 chained write
    {1'b1, 1'b1, 5'd5,  8'h55, 16'h001F},  // R6 short write
    {1'b0, 1'b1, 5'd16, 8'h00, 16'hFFFF},  // R7 read leaves mode
    {1'b1, 1'b1, 5'd16, 8'hFF, 16'h12C4}   // R5 chained write
  };

  initial begin
    int wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rx;
    waitClk(5);
    check("R8 mode at reset", {8'd0, chanMode}, 16'd0);
    check("R1 enable at reset", {15'd0, sdoEn}, 16'd0);
    rstN = 1'b1;
    waitClk(5);
    check("R1 idle enable", {15'd0, sdoEn}, 16'd0);

    for (int v = 0; v < 8; v++) begin
      logic sel = VEC[v][30];
      logic trail = VEC[v][29];
      int nb = int'(VEC[v][28:24]);
      logic [7:0] ch = VEC[v][23:16];
      logic [15:0] tx = VEC[v][15:0];
      serialCycle(sel, trail, nb, ch, tx, rx);
      check($sformatf("R2 R3 R4 rx vector %0d", v), rx, expRx(nb, ch, tx));
      if (sel && nb >= 8) expMode = tx[7:0];
      check($sformatf("R5 R6 R7 R9 mode vector %0d", v), {8'd0, chanMode}, {8'd0, expMode});
    end

    // R8: reset after a write clears the modes
    serialCycle(1'b1, 1'b1, 8, 8'h00, 16'h00FF, rx);
    check("R5 write FF", {8'd0, chanMode}, 16'h00FF);
    rstN = 1'b0;
    waitClk(3);
    check("R8 reset clears mode", {8'd0, chanMode}, 16'd0);
    rstN = 1'b1;
    waitClk(3);
    serialCycle(1'b0, 1'b1, 8, 8'h6E, 16'h0000, rx);
    check("R3 read after reset", rx, 16'h006E);
    check("R8 mode stays default", {8'd0, chanMode}, 16'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule